// File: doc/BRIEF.md
# Region Protection Address Translator

This block turns a 32-bit virtual address into a physical address and the rights that go with it, using a fixed split of the address space into eight equal 512 MB regions. The top three address bits pick a region directly, with no tag compare. Each region holds a physical region number and a 4-bit attribute code. The code is decoded into read, write and execute rights and a cache mode. The requested access kind (load, store or fetch) is then checked against those rights, and a fault cause is reported when it is not allowed.

A mode input selects between translating mode, which uses the eight-entry region table, and identity mode. In identity mode the physical address equals the virtual address, and the attribute of each region is taken from one 4-bit field of a 32-bit cache-attribute word. A single write port updates one table entry per cycle. Lookups are purely combinational on the current inputs and the stored table.

Top module: `region_xlate`

## Requirements
- R1: In translating mode (`xlate_en`=1) the region index is `va[31:29]`, and `pa` is the region's stored 3-bit physical region number in bits [31:29] with `va[28:0]` passed through unchanged.
- R2: After reset, table entry i holds physical region number i and attribute code 2, so every address maps to itself with read, write, execute and bypass caching.
- R3: Code 0 gives read+write with write-through. Code 1 gives read+write+execute with write-through. Code 2 gives read+write+execute with bypass. The `cache_mode` encoding is 0 none, 1 bypass, 2 write-through, 3 write-back, 4 isolate.
- R4: Code 3 gives execute only with write-back. Code 4 gives read+write+execute with write-back. Code 5 gives the same as code 4 in translating mode. Code 14 gives read+write with isolate.
- R5: Any code not named in R3 or R4 grants no right and reports cache mode 0.
- R6: With `acc_type` 0 = load, 1 = store and 2 = fetch (3 is handled as fetch), a missing read, write or execute right raises `fault` 1, 2 or 3 respectively. Otherwise `fault` is 0.
- R7: In identity mode (`xlate_en`=0) `pa` equals `va`, and the attribute is `cattr[4*va[31:29] +: 4]`. The table contents have no effect on the result.
- R8: In identity mode, code 5 is undefined and grants nothing. All other codes decode as in R3 to R5.
- R9: A table write takes effect from the cycle after `wr_en` is sampled. A lookup in the write cycle itself sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the region table |
| xlate_en | input | 1 | 1 = translate through the table, 0 = identity mode |
| va | input | 32 | Virtual address |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch |
| wr_en | input | 1 | Write one table entry |
| wr_idx | input | 3 | Entry to write |
| wr_base | input | 3 | New physical region number |
| wr_attr | input | 4 | New attribute code |
| cattr | input | 32 | Per-region attribute fields used in identity mode |
| pa | output | 32 | Physical address |
| rd_ok | output | 1 | Read right granted |
| wr_ok | output | 1 | Write right granted |
| ex_ok | output | 1 | Execute right granted |
| cache_mode | output | 3 | Cache mode code |
| fault | output | 2 | 0 none, 1 load, 2 store, 3 fetch prohibited |

## Verification
After reset, all eight regions are probed with every access kind to confirm the identity mapping and the reset attribute. In translating mode, all sixteen codes are written into each region with a scrambled physical number. Every access kind is then tried, which separates the index path and offset path of the address and the defined codes from the undefined ones. The same sweep in identity mode uses a cattr word whose other fields differ from the probed one, so a wrong field position or a leak from the table shows up, and code 5 tells the two decode tables apart. A write cycle with a lookup to the same region checks the old/new boundary.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    CM_NONE   = 3'd0,
    CM_BYPASS = 3'd1,
    CM_WTHRU  = 3'd2,
    CM_WBACK  = 3'd3,
    CM_ISOL   = 3'd4
  } cmode_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LOAD  = 2'd1,
    FLT_STORE = 2'd2,
    FLT_FETCH = 2'd3
  } flt_e;

  typedef struct packed {
    logic   rd;
    logic   wr;
    logic   ex;
    cmode_e cm;
  } perm_t;

  // Attribute code to rights; xl selects the translating-mode table
  function automatic perm_t decode_attr(input logic [3:0] code, input logic xl);
    perm_t p;
    p = '{rd: 1'b0, wr: 1'b0, ex: 1'b0, cm: CM_NONE};
    case (code)
      4'd0:  p = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, cm: CM_WTHRU};
      4'd1:  p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cm: CM_WTHRU};
      4'd2:  p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cm: CM_BYPASS};
      4'd3:  p = '{rd: 1'b0, wr: 1'b0, ex: 1'b1, cm: CM_WBACK};
      4'd4:  p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cm: CM_WBACK};
      4'd5:  if (xl) p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cm: CM_WBACK};
      4'd14: p = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, cm: CM_ISOL};
      default: p = '{rd: 1'b0, wr: 1'b0, ex: 1'b0, cm: CM_NONE};
    endcase
    return p;
  endfunction

  // Required right for an access kind, and the cause when it is missing
  function automatic flt_e check_access(input perm_t p, input acc_e acc);
    flt_e f;
    case (acc)
      ACC_LOAD:  f = p.rd ? FLT_NONE : FLT_LOAD;
      ACC_STORE: f = p.wr ? FLT_NONE : FLT_STORE;
      default:   f = p.ex ? FLT_NONE : FLT_FETCH;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/rgn_table.sv
module rgn_table #(
  parameter int IDX_W    = 3,
  parameter int ATTR_W   = 4,
  parameter int RST_ATTR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  wr_base,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  rd_base,
  output logic [ATTR_W-1:0] rd_attr
);
  localparam int NREG = 1 << IDX_W;

  logic [NREG-1:0][IDX_W-1:0]  base_q;
  logic [NREG-1:0][ATTR_W-1:0] attr_q;
  logic [NREG-1:0]             ent_we;

  for (genvar g = 0; g < NREG; g++) begin : g_we
    assign ent_we[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n) begin
        base_q[i] <= IDX_W'(i);
        attr_q[i] <= ATTR_W'(RST_ATTR);
      end else if (ent_we[i]) begin
        base_q[i] <= wr_base;
        attr_q[i] <= wr_attr;
      end
    end
  end

  assign rd_base = base_q[rd_idx];
  assign rd_attr = attr_q[rd_idx];
endmodule

// File: rtl/rgn_attr_sel.sv
module rgn_attr_sel #(
  parameter int IDX_W  = 3,
  parameter int ATTR_W = 4
) (
  input  logic                         xlate_en,
  input  logic [IDX_W-1:0]             idx,
  input  logic [ATTR_W-1:0]            tbl_attr,
  input  logic [(ATTR_W<<IDX_W)-1:0]   cattr,
  output logic [ATTR_W-1:0]            attr
);
  logic [ATTR_W-1:0] cattr_field;

  assign cattr_field = cattr[idx*ATTR_W +: ATTR_W];
  assign attr        = xlate_en ? tbl_attr : cattr_field;
endmodule

// File: rtl/rgn_perm.sv
module rgn_perm (
  input  logic       xlate_en,
  input  logic [3:0] attr,
  input  logic [1:0] acc_type,
  output logic       rd_ok,
  output logic       wr_ok,
  output logic       ex_ok,
  output logic [2:0] cache_mode,
  output logic [1:0] fault
);
  import rgn_pkg::*;

  perm_t p;
  flt_e  f;

  always_comb begin
    p = decode_attr(attr, xlate_en);
    f = check_access(p, acc_e'(acc_type));
  end

  assign rd_ok      = p.rd;
  assign wr_ok      = p.wr;
  assign ex_ok      = p.ex;
  assign cache_mode = p.cm;
  assign fault      = f;
endmodule

// File: rtl/region_xlate.sv
module region_xlate #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int ATTR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       xlate_en,
  input  logic [ADDR_W-1:0]          va,
  input  logic [1:0]                 acc_type,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [IDX_W-1:0]           wr_base,
  input  logic [ATTR_W-1:0]          wr_attr,
  input  logic [(ATTR_W<<IDX_W)-1:0] cattr,
  output logic [ADDR_W-1:0]          pa,
  output logic                       rd_ok,
  output logic                       wr_ok,
  output logic                       ex_ok,
  output logic [2:0]                 cache_mode,
  output logic [1:0]                 fault
);
  localparam int OFF_W = ADDR_W - IDX_W;

  // Named internal events for the checker
  logic [IDX_W-1:0]  rgn_idx;
  logic [IDX_W-1:0]  tbl_base;
  logic [ATTR_W-1:0] tbl_attr;
  logic [ATTR_W-1:0] sel_attr;

  assign rgn_idx = va[ADDR_W-1 -: IDX_W];

  rgn_table #(.IDX_W(IDX_W), .ATTR_W(ATTR_W), .RST_ATTR(2)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_base (wr_base),
    .wr_attr (wr_attr),
    .rd_idx  (rgn_idx),
    .rd_base (tbl_base),
    .rd_attr (tbl_attr)
  );

  rgn_attr_sel #(.IDX_W(IDX_W), .ATTR_W(ATTR_W)) u_sel (
    .xlate_en (xlate_en),
    .idx      (rgn_idx),
    .tbl_attr (tbl_attr),
    .cattr    (cattr),
    .attr     (sel_attr)
  );

  rgn_perm u_perm (
    .xlate_en   (xlate_en),
    .attr       (sel_attr),
    .acc_type   (acc_type),
    .rd_ok      (rd_ok),
    .wr_ok      (wr_ok),
    .ex_ok      (ex_ok),
    .cache_mode (cache_mode),
    .fault      (fault)
  );

  assign pa = xlate_en ? {tbl_base, va[OFF_W-1:0]} : va;
endmodule

// File: rtl/region_xlate_chk.sv
module region_xlate_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int ATTR_W = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       xlate_en,
  input logic [ADDR_W-1:0]          va,
  input logic [1:0]                 acc_type,
  input logic                       wr_en,
  input logic [IDX_W-1:0]           wr_idx,
  input logic [IDX_W-1:0]           wr_base,
  input logic [ATTR_W-1:0]          sel_attr,
  input logic [ADDR_W-1:0]          pa,
  input logic                       rd_ok,
  input logic                       wr_ok,
  input logic                       ex_ok,
  input logic [2:0]                 cache_mode,
  input logic [1:0]                 fault
);
  localparam int OFF_W = ADDR_W - IDX_W;

  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    pa[OFF_W-1:0] == va[OFF_W-1:0]);

  a_r7_identity: assert property (@(posedge clk) disable iff (!rst_n)
    !xlate_en |-> pa == va);

  a_r9_write_next: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && xlate_en &&
     va[ADDR_W-1 -: IDX_W] == $past(wr_idx)) |-> pa[ADDR_W-1 -: IDX_W] == $past(wr_base));

  a_r5_none_no_rights: assert property (@(posedge clk) disable iff (!rst_n)
    cache_mode == 3'd0 |-> !(rd_ok || wr_ok || ex_ok));

  a_r6_load_fault: assert property (@(posedge clk) disable iff (!rst_n)
    acc_type == 2'd0 |-> ((fault == 2'd1) == !rd_ok) && (fault == 2'd0 || fault == 2'd1));

  a_r6_store_fault: assert property (@(posedge clk) disable iff (!rst_n)
    acc_type == 2'd1 |-> ((fault == 2'd2) == !wr_ok) && (fault == 2'd0 || fault == 2'd2));

  a_r6_fetch_fault: assert property (@(posedge clk) disable iff (!rst_n)
    acc_type[1] |-> ((fault == 2'd3) == !ex_ok) && (fault == 2'd0 || fault == 2'd3));

  a_r8_code5_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (!xlate_en && sel_attr == 4'd5) |-> !(rd_ok || wr_ok || ex_ok) && cache_mode == 3'd0);
endmodule

bind region_xlate region_xlate_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ATTR_W(ATTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xlate_en   (xlate_en),
  .va         (va),
  .acc_type   (acc_type),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_base    (wr_base),
  .sel_attr   (sel_attr),
  .pa         (pa),
  .rd_ok      (rd_ok),
  .wr_ok      (wr_ok),
  .ex_ok      (ex_ok),
  .cache_mode (cache_mode),
  .fault      (fault)
);

// File: tb/region_xlate_test.sv
`timescale 1ns/1ps
module region_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlate_en = 1'b1;
  logic [31:0] va = '0;
  logic [1:0]  acc_type = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [2:0]  wr_base = '0;
  logic [3:0]  wr_attr = '0;
  logic [31:0] cattr = '0;
  logic [31:0] pa;
  logic        rd_ok, wr_ok, ex_ok;
  logic [2:0]  cache_mode;
  logic [1:0]  fault;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [2:0] sh_base [8];
  logic [3:0] sh_attr [8];

  always #2.5 clk = ~clk;

  region_xlate uut (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .va(va), .acc_type(acc_type),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base), .wr_attr(wr_attr),
    .cattr(cattr), .pa(pa), .rd_ok(rd_ok), .wr_ok(wr_ok), .ex_ok(ex_ok),
    .cache_mode(cache_mode), .fault(fault)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Expected rights as {rd,wr,ex}, built from membership sets
  function automatic logic [2:0] exp_rwx(input int code, input bit xl);
    bit rw, x;
    rw = (code == 0) || (code == 1) || (code == 2) || (code == 4) || (code == 14) ||
         (code == 5 && xl);
    x  = (code >= 1 && code <= 4) || (code == 5 && xl);
    return {rw, rw, x};
  endfunction

  function automatic logic [2:0] exp_cm(input int code, input bit xl);
    if (code <= 1) return 3'd2;
    if (code == 2) return 3'd1;
    if (code == 3 || code == 4 || (code == 5 && xl)) return 3'd3;
    if (code == 14) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [1:0] exp_flt(input logic [2:0] rwx, input int acc);
    if (acc == 0) return rwx[2] ? 2'd0 : 2'd1;
    if (acc == 1) return rwx[1] ? 2'd0 : 2'd2;
    return rwx[0] ? 2'd0 : 2'd3;
  endfunction

  task automatic do_write(input int idx, input int base, input int code);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_base = 3'(base); wr_attr = 4'(code);
    @(negedge clk);
    wr_en = 1'b0;
    sh_base[idx] = 3'(base);
    sh_attr[idx] = 4'(code);
  endtask

  // Drive a lookup after a falling edge and compare every output
  task automatic probe(input string rq_map, input string rq_attr, input int r,
                       input int acc, input logic [28:0] off, input int code,
                       input bit xl, input logic [31:0] exp_pa);
    logic [2:0] rwx;
    @(negedge clk);
    va = {3'(r), off};
    acc_type = 2'(acc);
    #1;
    rwx = exp_rwx(code, xl);
    chk(rq_map, pa, exp_pa);
    chk(rq_attr, {29'd0, rd_ok, wr_ok, ex_ok}, {29'd0, rwx});
    chk(rq_attr, {29'd0, cache_mode}, {29'd0, exp_cm(code, xl)});
    chk("R6", {30'd0, fault}, {30'd0, exp_flt(rwx, acc)});
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      sh_base[i] = 3'(i);
      sh_attr[i] = 4'd2;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset mapping and attribute in every region
    for (int r = 0; r < 8; r++)
      for (int a = 0; a < 3; a++)
        probe("R2", "R2", r, a, 29'h0ABC_DEF ^ 29'(r * 77), 2, 1'b1,
              {3'(r), 29'h0ABC_DEF ^ 29'(r * 77)});

    // R1 R3 R4 R5 R6: translating mode, all codes in all regions
    for (int code = 0; code < 16; code++)
      for (int r = 0; r < 8; r++) begin
        do_write(r, r ^ 5, code);
        for (int a = 0; a < 4; a++) begin
          logic [28:0] off;
          off = 29'(32'h1357_9BDF * (code + 1) + r * 4099 + a);
          probe("R1", (code <= 2) ? "R3" : ((code == 3 || code == 4 || code == 5 || code == 14) ? "R4" : "R5"),
                r, a, off, code, 1'b1, {sh_base[r], off});
        end
      end

    // R7 R8: identity mode, field of the probed region differs from the rest
    xlate_en = 1'b0;
    for (int code = 0; code < 16; code++)
      for (int r = 0; r < 8; r++) begin
        logic [31:0] cw;
        cw = {8{4'(code + 7)}};
        cw[r*4 +: 4] = 4'(code);
        cattr = cw;
        for (int a = 0; a < 3; a++) begin
          logic [28:0] off;
          off = 29'(32'h2468_ACE1 ^ (code * 31 + r * 517 + a));
          probe("R7", (code == 5) ? "R8" : "R7", r, a, off, code, 1'b0, {3'(r), off});
        end
      end

    // R9: lookup during the write cycle sees old entry, next cycle the new one
    xlate_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd6; wr_base = 3'd1; wr_attr = 4'd3;
    va = {3'd6, 29'h0000_1234};
    acc_type = 2'd0;
    #1;
    chk("R9", {29'd0, pa[31:29]}, {29'd0, sh_base[6]});
    chk("R9", {29'd0, rd_ok, wr_ok, ex_ok}, {29'd0, exp_rwx(int'(sh_attr[6]), 1'b1)});
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R9", pa, {3'd1, 29'h0000_1234});
    chk("R9", {30'd0, fault}, 32'd1);
    chk("R9", {29'd0, cache_mode}, 32'd3);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule